// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing pulses for a serial transmitter and receiver from the peripheral clock. Software programs a fixed-point divisor: an integer mantissa and a 4-bit fraction counted in sixteenths. The block emits one oversample pulse per divisor period, which is sixteen times the bit rate. It also emits a bit pulse on every sixteenth oversample pulse. The bit rate is therefore Fclk / (16 × (mantissa + fraction/16)). Transmit and receive share one setting, and the highest rate is Fclk/16.

A 4-bit accumulator spreads the fraction over the oversample periods. Each period is normally mantissa clocks long. In every period the fraction is added to the accumulator, and a period whose addition carries out of four bits lasts one clock longer. Over sixteen periods, exactly `fraction` of them are stretched, so the average period equals the programmed divisor. The coarser the clock relative to the bit rate, the larger the jitter and error of each period.

The divisor is held in a register that changes only on a write strobe. A write also resets the period counter, the accumulator and the sixteen-pulse counter, so the new rate starts from a clean phase. Software must not rewrite the divisor while a frame is in flight. A mantissa of zero is invalid and keeps both pulses low. There is no streaming data path, so all pins are plain control and status.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor register holds mantissa 0 and fraction 0, so `os_tick`, `bit_tick` and `div_ok` are all low until a write.
- R2: With fraction 0 and mantissa M ≥ 1, `os_tick` is a single-cycle pulse every M clocks.
- R3: The accumulator starts at 0 after a write and advances by the fraction, modulo 16, at each `os_tick`. A period during which accumulator + fraction ≥ 16 lasts M+1 clocks; every other period lasts M clocks.
- R4: After a write of mantissa M and fraction F (M ≥ 1), the sixteenth `os_tick` falls in clock 16·M+F−1 counted from the write, so sixteen periods span exactly 16·M+F clocks.
- R5: While the stored mantissa is 0, `div_ok` is low and neither pulse is ever asserted.
- R6: `bit_tick` is asserted only together with `os_tick`, on the 16th, 32nd, 48th, … oversample pulse after a write.
- R7: Take cfg_we sampled high at a clock edge as the write edge. The clock cycle right after that edge is cycle 0. The first `os_tick` then falls in cycle M−1 (the fraction only stretches later periods), whatever phase the old setting was in.
- R8: Changes on `cfg_mant` and `cfg_frac` while `cfg_we` is low have no effect on either pulse.
- R9: With mantissa 1 and fraction 0, `os_tick` is high in every cycle and `bit_tick` pulses once every 16 clocks (the Fclk/16 maximum).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Divisor write strobe, sampled at the rising edge |
| cfg_mant | input | MANT_W | Integer part of the divisor |
| cfg_frac | input | 4 | Fractional part of the divisor, in sixteenths |
| os_tick | output | 1 | Oversample pulse, sixteen per bit |
| bit_tick | output | 1 | Bit-rate pulse, on every 16th oversample pulse |
| div_ok | output | 1 | High while the stored mantissa is non-zero |

## Verification
Both pulses are driven from registers through plain gates, so a pulse is due in a known cycle counted from the clock edge that captured the write: the first oversample pulse falls M−1 cycles after that edge, and each later one is a period length further on. Every scenario task raises the write strobe at a falling edge. It then numbers the cycles from the falling edge that follows the capturing rising edge, and samples both pulses at every falling edge. Each sample is compared with the pulse times the task computes from the period rule in R3. The R4 and R6 checks compare the cycle of the sixteenth pulse with 16·M+F−1.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // The fraction is counted in sixteenths; sixteen oversample pulses form one bit.
  localparam int unsigned FRAC_W = 4;
  localparam int unsigned OVS_LOG2 = 4;
  localparam int unsigned OVS_RATIO = 1 << OVS_LOG2;

  // A period is stretched when adding the fraction to the accumulator carries.
  function automatic logic frac_carry(input logic [FRAC_W-1:0] acc,
                                      input logic [FRAC_W-1:0] frac);
    logic [FRAC_W:0] total;
    total = {1'b0, acc} + {1'b0, frac};
    return total[FRAC_W];
  endfunction

endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg
  import baud_pkg::*;
#(
  parameter int unsigned MANT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MANT_W-1:0] wr_mant,
  input  logic [FRAC_W-1:0] wr_frac,
  output logic [MANT_W-1:0] mant_q,
  output logic [FRAC_W-1:0] frac_q
);

  // The divisor moves only on an explicit write; anything else on the inputs is ignored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_q <= '0;
      frac_q <= '0;
    end else if (wr_en) begin
      mant_q <= wr_mant;
      frac_q <= wr_frac;
    end
  end

endmodule

// File: rtl/baud_period_ctr.sv
module baud_period_ctr
  import baud_pkg::*;
#(
  parameter int unsigned MANT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [MANT_W-1:0] mant,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick,
  output logic              valid,
  output logic [MANT_W-1:0] cnt_o
);

  localparam int unsigned LAST_W = MANT_W + 1;

  logic [MANT_W-1:0] cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_next;
  logic              stretch;
  logic [LAST_W-1:0] last_idx;

  assign valid    = (mant != '0);
  assign stretch  = frac_carry(acc_q, frac);
  assign acc_next = acc_q + frac;
  // The last count of this period: mantissa-1, plus one when the accumulator carries.
  assign last_idx = {1'b0, mant} - LAST_W'(1) + LAST_W'(stretch);
  assign tick     = valid && ({1'b0, cnt_q} == last_idx);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!valid) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      acc_q <= acc_next;
    end else begin
      cnt_q <= cnt_q + MANT_W'(1);
    end
  end

endmodule

// File: rtl/baud_bit_ctr.sv
module baud_bit_ctr
  import baud_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic os_tick,
  output logic bit_tick
);

  logic [OVS_LOG2-1:0] sub_q;

  assign bit_tick = os_tick && (sub_q == {OVS_LOG2{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (restart) begin
      sub_q <= '0;
    end else if (os_tick) begin
      sub_q <= sub_q + OVS_LOG2'(1);
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned MANT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MANT_W-1:0] cfg_mant,
  input  logic [3:0]        cfg_frac,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              div_ok
);

  logic [MANT_W-1:0] mant_q;
  logic [FRAC_W-1:0] frac_q;
  logic [MANT_W-1:0] cnt_q;

  baud_div_reg #(.MANT_W(MANT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_mant (cfg_mant),
    .wr_frac (cfg_frac),
    .mant_q  (mant_q),
    .frac_q  (frac_q)
  );

  // The write edge that loads the divisor also clears both counters.
  baud_period_ctr #(.MANT_W(MANT_W)) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_we),
    .mant    (mant_q),
    .frac    (frac_q),
    .tick    (os_tick),
    .valid   (div_ok),
    .cnt_o   (cnt_q)
  );

  baud_bit_ctr u_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cfg_we),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
  );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int unsigned MANT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              os_tick,
  input logic              bit_tick,
  input logic              div_ok,
  input logic [MANT_W-1:0] mant_q,
  input logic [3:0]        frac_q,
  input logic [MANT_W-1:0] cnt_q
);

  // R5: an invalid divisor keeps both pulses quiet
  a_r5_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok |-> (!os_tick && !bit_tick));

  // R6: the bit pulse never appears without an oversample pulse
  a_r6_bit_within_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  // R7: a write restarts the period count from zero
  a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt_q == '0));

  // R8: the stored divisor holds when no write is made
  a_r8_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(mant_q) && $stable(frac_q)));

  // R2: with a mantissa above one the pulse lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && !cfg_we && (mant_q > MANT_W'(1))) |=> !os_tick);

  // R3: a period never runs past mantissa+1 clocks
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= mant_q);

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.MANT_W(MANT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .os_tick  (os_tick),
  .bit_tick (bit_tick),
  .div_ok   (div_ok),
  .mant_q   (mant_q),
  .frac_q   (frac_q),
  .cnt_q    (cnt_q)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;

  localparam int unsigned MANT_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [MANT_W-1:0] cfg_mant = '0;
  logic [3:0]        cfg_frac = '0;
  logic              os_tick;
  logic              bit_tick;
  logic              div_ok;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  frac_baud_gen #(.MANT_W(MANT_W)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mant (cfg_mant),
    .cfg_frac (cfg_frac),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .div_ok   (div_ok)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Write a divisor, then compare both pulses against the period rule cycle by cycle.
  task automatic run_pattern(input int mant, input int frac, input int ncyc,
                             input int junk_mant, input int junk_frac,
                             input string req, output int pos16, output int n_os);
    int acc, t_next, os_err, bit_err, first_os, first_bit;
    logic exp_os, exp_bit;
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_mant = MANT_W'(mant);
    cfg_frac = 4'(frac);
    @(posedge clk);
    acc = 0;
    t_next = mant - 1 + (((acc + frac) >= 16) ? 1 : 0);
    os_err = 0; bit_err = 0; first_os = -1; first_bit = -1;
    n_os = 0; pos16 = -1;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c == 0) begin
        cfg_we   = 1'b0;
        cfg_mant = MANT_W'(junk_mant);
        cfg_frac = 4'(junk_frac);
      end
      exp_os  = (mant != 0) && (c == t_next);
      exp_bit = exp_os && ((n_os % 16) == 15);
      if (os_tick !== exp_os) begin
        os_err++;
        if (first_os < 0) first_os = c;
      end
      if (bit_tick !== exp_bit) begin
        bit_err++;
        if (first_bit < 0) first_bit = c;
      end
      if (exp_os) begin
        n_os++;
        if (n_os == 16) pos16 = c;
        acc = (acc + frac) % 16;
        t_next = c + mant + (((acc + frac) >= 16) ? 1 : 0);
      end
    end
    check(os_err == 0, req, $sformatf("os_tick mismatches (first at cycle %0d)", first_os),
          os_err, 0);
    check(bit_err == 0, {req, " R6"},
          $sformatf("bit_tick mismatches (first at cycle %0d)", first_bit), bit_err, 0);
  endtask

  task automatic t_reset;
    int seen;
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (os_tick || bit_tick || div_ok) seen++;
    end
    check(seen == 0, "R1", "outputs active after reset", seen, 0);
  endtask

  task automatic t_integer;
    int p16, nos;
    run_pattern(5, 0, 400, 5, 0, "R2 R7", p16, nos);
    check(p16 == 16*5 - 1, "R4", "16th pulse cycle M=5 F=0", p16, 79);
  endtask

  task automatic t_fraction;
    int p16, nos;
    run_pattern(3, 5, 300, 3, 5, "R3", p16, nos);
    check(p16 == 16*3 + 5 - 1, "R4", "16th pulse cycle M=3 F=5", p16, 52);
    run_pattern(6, 11, 400, 6, 11, "R3", p16, nos);
    check(p16 == 16*6 + 11 - 1, "R4", "16th pulse cycle M=6 F=11", p16, 106);
  endtask

  task automatic t_max_rate;
    int p16, nos;
    run_pattern(1, 0, 64, 1, 0, "R9", p16, nos);
    check(nos == 64, "R9", "pulses in 64 cycles", nos, 64);
    run_pattern(1, 15, 100, 1, 15, "R3", p16, nos);
    check(p16 == 16 + 15 - 1, "R4", "16th pulse cycle M=1 F=15", p16, 30);
  endtask

  task automatic t_invalid;
    int p16, nos;
    run_pattern(0, 9, 100, 0, 9, "R5", p16, nos);
    check(div_ok == 1'b0, "R5", "div_ok with mantissa 0", int'(div_ok), 0);
  endtask

  task automatic t_ignore;
    int p16, nos;
    run_pattern(4, 0, 200, 9, 3, "R8", p16, nos);
    check(nos == 50, "R8", "pulse count with stray inputs", nos, 50);
  endtask

  task automatic t_rewrite;
    int p16, nos;
    @(negedge clk);
    cfg_we = 1'b1; cfg_mant = MANT_W'(7); cfg_frac = 4'(0);
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (10) @(negedge clk);
    run_pattern(2, 8, 200, 2, 8, "R7", p16, nos);
    check(p16 == 16*2 + 8 - 1, "R7", "16th pulse after mid-period rewrite", p16, 39);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_integer();
    t_fraction();
    t_max_rate();
    t_invalid();
    t_ignore();
    t_rewrite();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule